// File: doc/BRIEF.md
# Word-Wide CRC-5 Update Engine

This block keeps a running 5-bit cyclic redundancy check and folds a whole 4-bit data word into it on every clock that carries valid data. It does not shift one bit per cycle. A fixed XOR network computes in one step the result that four bit-serial LFSR steps would give. Each output bit of that network is the parity of a chosen subset of the current check bits and the incoming data bits. The subsets are derived at elaboration by superposition. The serial step is run on each single-bit data value with the state cleared, and on each single-bit state value with the data cleared. The column for an output bit then lists the inputs that feed it.

A producer pulses the init strobe at the start of a message, which sets the check to all ones. It then presents one word per cycle with the valid qualifier high, and reads the running check on the output. The generator, data width and check width are parameters. Defaults give the generator x^5+x^2+1 (0x05 with the top term implicit) over a 4-bit word. The output is the raw register, with no inversion or reversal.

Top module: `crc_word_engine`

## Requirements
- R1: A synchronous active-high reset sets the check register so that `crc_o` reads 5'b11111 after the clock edge that samples reset.
- R2: When `init_i` is high at a clock edge, `crc_o` reads 5'b11111 after that edge.
- R3: If `init_i` and `valid_i` are both high at an edge, the init wins: `crc_o` reads 5'b11111 and the data word is discarded.
- R4: With `init_i` and `valid_i` both low, `crc_o` keeps its value across the edge, whatever `data_i` carries.
- R5: With `valid_i` high and `init_i` low, the new check equals four serial steps applied to the old check, taking `data_i[0]` first and `data_i[3]` last. One serial step is fb = crc[4] ^ d, then crc = {crc[3:0],1'b0} ^ (fb ? 5'b00101 : 5'b00000).
- R6: Words presented on consecutive cycles are all absorbed, with no bubble. Each result is visible on `crc_o` directly after the edge that took the word.
- R7: The output is the uncomplemented, unreflected register. After an init followed by the word 4'h0, `crc_o` reads 5'h06.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| init_i | input | 1 | Sets the check to all ones |
| valid_i | input | 1 | Qualifies `data_i` for absorption |
| data_i | input | DATA_W | Data word, bit 0 enters first |
| crc_o | output | CRC_W | Running check value |

## Verification
On every cycle, the assertions check the reset and init loads, the init-over-data priority, hold with no valid word, and a comparison of each accepted word's result against the serial step function. Only the bench scenarios can show that the XOR network matches an independently written bit-serial model across chained words: every pair of words after init, long random streams with idle gaps and re-inits, and the known value 5'h06 for a zero word.

// File: rtl/crc_word_pkg.sv
package crc_word_pkg;

  localparam int MAX_W = 32;

  function automatic logic [MAX_W-1:0] width_mask(input int w);
    logic [MAX_W-1:0] m;
    m = '0;
    for (int i = 0; i < MAX_W; i++) begin
      if (i < w) m[i] = 1'b1;
    end
    return m;
  endfunction

  // One bit-serial LFSR step: feedback is the top bit XOR the data bit.
  function automatic logic [MAX_W-1:0] serial_step(
    input logic [MAX_W-1:0] crc,
    input logic             d,
    input logic [MAX_W-1:0] poly,
    input int               w
  );
    logic             fb;
    logic [MAX_W-1:0] nxt;
    fb  = crc[w-1] ^ d;
    nxt = (crc << 1) & width_mask(w);
    if (fb) nxt = nxt ^ (poly & width_mask(w));
    return nxt;
  endfunction

  // A whole word, least significant bit applied first.
  function automatic logic [MAX_W-1:0] serial_word(
    input logic [MAX_W-1:0] crc,
    input logic [MAX_W-1:0] data,
    input int               dw,
    input logic [MAX_W-1:0] poly,
    input int               w
  );
    logic [MAX_W-1:0] c;
    c = crc;
    for (int i = 0; i < dw; i++) begin
      c = serial_step(c, data[i], poly, w);
    end
    return c;
  endfunction

  // Data inputs that feed output bit 'col' (state held at zero).
  function automatic logic [MAX_W-1:0] data_column(
    input int col, input int dw, input logic [MAX_W-1:0] poly, input int w
  );
    logic [MAX_W-1:0] m;
    logic [MAX_W-1:0] r;
    m = '0;
    for (int j = 0; j < dw; j++) begin
      r    = serial_word('0, MAX_W'(1) << j, dw, poly, w);
      m[j] = r[col];
    end
    return m;
  endfunction

  // State inputs that feed output bit 'col' (data held at zero).
  function automatic logic [MAX_W-1:0] state_column(
    input int col, input int dw, input logic [MAX_W-1:0] poly, input int w
  );
    logic [MAX_W-1:0] m;
    logic [MAX_W-1:0] r;
    m = '0;
    for (int k = 0; k < w; k++) begin
      r    = serial_word(MAX_W'(1) << k, '0, dw, poly, w);
      m[k] = r[col];
    end
    return m;
  endfunction

endpackage

// File: rtl/crc_xor_net.sv
module crc_xor_net
  import crc_word_pkg::*;
#(
  parameter int              DATA_W = 4,
  parameter int              CRC_W  = 5,
  parameter logic [CRC_W-1:0] POLY  = 5'h05
) (
  input  logic [CRC_W-1:0]  state_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  next_o
);

  localparam logic [MAX_W-1:0] POLY_X = MAX_W'(POLY);

  for (genvar i = 0; i < CRC_W; i++) begin : g_col
    localparam logic [MAX_W-1:0] DSEL = data_column(i, DATA_W, POLY_X, CRC_W);
    localparam logic [MAX_W-1:0] SSEL = state_column(i, DATA_W, POLY_X, CRC_W);
    assign next_o[i] = (^(data_i & DSEL[DATA_W-1:0])) ^ (^(state_i & SSEL[CRC_W-1:0]));
  end

endmodule

// File: rtl/crc_ctrl.sv
module crc_ctrl (
  input  logic init_i,
  input  logic valid_i,
  output logic init_fire_o,
  output logic upd_fire_o
);

  // Init outranks a data word in the same cycle.
  assign init_fire_o = init_i;
  assign upd_fire_o  = valid_i & ~init_i;

endmodule

// File: rtl/crc_state_reg.sv
module crc_state_reg #(
  parameter int CRC_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_ones_i,
  input  logic             upd_i,
  input  logic [CRC_W-1:0] next_i,
  output logic [CRC_W-1:0] q_o
);

  always_ff @(posedge clk) begin
    if (rst || load_ones_i) begin
      q_o <= '1;
    end else if (upd_i) begin
      q_o <= next_i;
    end
  end

endmodule

// File: rtl/crc_word_engine.sv
module crc_word_engine #(
  parameter int               DATA_W = 4,
  parameter int               CRC_W  = 5,
  parameter logic [CRC_W-1:0] POLY   = 5'h05
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);

  logic             init_fire;
  logic             upd_fire;
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_next;

  crc_ctrl u_ctrl (
    .init_i      (init_i),
    .valid_i     (valid_i),
    .init_fire_o (init_fire),
    .upd_fire_o  (upd_fire)
  );

  crc_xor_net #(
    .DATA_W (DATA_W),
    .CRC_W  (CRC_W),
    .POLY   (POLY)
  ) u_net (
    .state_i (crc_q),
    .data_i  (data_i),
    .next_o  (crc_next)
  );

  crc_state_reg #(
    .CRC_W (CRC_W)
  ) u_reg (
    .clk         (clk),
    .rst         (rst),
    .load_ones_i (init_fire),
    .upd_i       (upd_fire),
    .next_i      (crc_next),
    .q_o         (crc_q)
  );

  assign crc_o = crc_q;

endmodule

// File: rtl/crc_word_chk.sv
module crc_word_chk
  import crc_word_pkg::*;
#(
  parameter int               DATA_W = 4,
  parameter int               CRC_W  = 5,
  parameter logic [CRC_W-1:0] POLY   = 5'h05
) (
  input logic              clk,
  input logic              rst,
  input logic              init_i,
  input logic              valid_i,
  input logic [DATA_W-1:0] data_i,
  input logic [CRC_W-1:0]  crc_o,
  input logic              init_fire,
  input logic              upd_fire
);

  localparam logic [MAX_W-1:0] POLY_X = MAX_W'(POLY);

  // R1
  reset_ones_chk: assert property (@(posedge clk) rst |=> crc_o == '1);

  // R2
  init_ones_chk: assert property (@(posedge clk) disable iff (rst)
    init_i |=> crc_o == '1);

  // R3
  init_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (init_i && valid_i) |=> crc_o == '1);

  // R3
  fire_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({init_fire, upd_fire}));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!init_i && !valid_i) |=> $stable(crc_o));

  // R5
  word_step_chk: assert property (@(posedge clk) disable iff (rst)
    upd_fire |=> crc_o == CRC_W'(serial_word(MAX_W'($past(crc_o)),
                                             MAX_W'($past(data_i)),
                                             DATA_W, POLY_X, CRC_W)));

endmodule

bind crc_word_engine crc_word_chk #(
  .DATA_W (DATA_W),
  .CRC_W  (CRC_W),
  .POLY   (POLY)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .init_i    (init_i),
  .valid_i   (valid_i),
  .data_i    (data_i),
  .crc_o     (crc_o),
  .init_fire (init_fire),
  .upd_fire  (upd_fire)
);

// File: tb/crc_word_engine_tb.sv
module crc_word_engine_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       init_i = 1'b0;
  logic       valid_i = 1'b0;
  logic [3:0] data_i = 4'h0;
  logic [4:0] crc_o;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;
  logic [4:0] model = 5'h1f;

  always #10 clk = ~clk;

  crc_word_engine u_dut (
    .clk     (clk),
    .rst     (rst),
    .init_i  (init_i),
    .valid_i (valid_i),
    .data_i  (data_i),
    .crc_o   (crc_o)
  );

  // Bench's own serial model: x^5 + x^2 + 1 taps at bits 2 and 0.
  function automatic logic [4:0] ref_bit(input logic [4:0] c, input logic d);
    logic fb;
    logic [4:0] r;
    fb = c[4] ^ d;
    r  = {c[3:0], 1'b0};
    r[2] = r[2] ^ fb;
    r[0] = r[0] ^ fb;
    return r;
  endfunction

  function automatic logic [4:0] ref_word(input logic [4:0] c, input logic [3:0] w);
    logic [4:0] r;
    r = c;
    for (int b = 0; b < 4; b++) r = ref_bit(r, w[b]);
    return r;
  endfunction

  task automatic check(input string req, input logic [4:0] exp);
    compared++;
    if (crc_o !== exp) begin
      mismatched++;
      $display("FAIL %s: crc_o=%h expected=%h", req, crc_o, exp);
    end
  endtask

  // Drive one cycle, update the model at the edge, sample 1 ns later.
  task automatic cyc(input logic r, input logic in, input logic v, input logic [3:0] d);
    @(negedge clk);
    rst = r; init_i = in; valid_i = v; data_i = d;
    @(posedge clk);
    if (r || in) model = 5'h1f;
    else if (v) model = ref_word(model, d);
    #1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : stim
    logic [4:0] held;
    cyc(1, 0, 0, 4'h0);
    cyc(1, 0, 1, 4'h9);
    check("R1 reset value", 5'h1f);

    // R7 known value: init then word 0 gives 5'h06
    cyc(0, 1, 0, 4'h0);
    check("R2 init value", 5'h1f);
    cyc(0, 0, 1, 4'h0);
    check("R7 zero word after init", 5'h06);

    // R5 R6 exhaustive pairs of back-to-back words after init
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        cyc(0, 1, 0, 4'h0);
        cyc(0, 0, 1, 4'(a));
        check("R5 first word", model);
        cyc(0, 0, 1, 4'(b));
        check("R6 second word back-to-back", model);
      end
    end

    // R4 idle hold with data toggling
    cyc(0, 0, 1, 4'hb);
    held = crc_o;
    for (int k = 0; k < 16; k++) begin
      cyc(0, 0, 0, 4'(k));
      check("R4 hold while not valid", held);
    end

    // R3 init with valid data
    cyc(0, 0, 1, 4'h5);
    cyc(0, 1, 1, 4'hc);
    check("R3 init beats data", 5'h1f);

    // R1 mid-stream reset
    cyc(0, 0, 1, 4'h3);
    cyc(1, 0, 1, 4'h7);
    check("R1 reset mid-stream", 5'h1f);
    cyc(0, 0, 1, 4'h7);
    check("R5 after reset", model);

    // R5 R4 R2 random streams
    for (int n = 0; n < 4000; n++) begin
      int sel;
      sel = $urandom_range(0, 19);
      cyc(0, sel == 0, sel < 13, 4'($urandom_range(0, 15)));
      check("R5 random stream", model);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule